// File: doc/BRIEF.md
# Five-Stage Subtract-and-Branch-if-Negative Pipeline

This block is the core of a one-instruction processor. Every instruction is three consecutive memory words A, B and C. It subtracts the word at address A from the word at address B, writes the difference back to B, and continues at C when the difference is negative. Otherwise it continues at the next instruction. The core overlaps instructions in five stages, in this order: fetch, operand read, compute, write and branch. The branch is therefore decided only after the write has already happened.

Memory is split into three single-ported banks, interleaved by address modulo 3. Each bank serves one access per cycle. A fetch needs all three banks at once. A read needs the banks of A and B, and a write needs the bank of B.

The control logic gives the oldest instruction first claim on the banks and holds younger ones back. It also makes reads and fetches wait while an older instruction still has a write pending to a word they need. A taken branch discards every younger instruction and restarts fetch at its target.

The read stage walks through two named phases, RD_FIRST and RD_SECOND. The transition RD_FIRST to RD_SECOND is taken when A and B sit in the same bank at different addresses and A has just been read. Any advance, any flush or any new fetch returns the stage to RD_FIRST. The core itself has two run states, ST_RUN and ST_HALT. The only transition, ST_RUN to ST_HALT, happens when an instruction branches to its own address.

Top module: `subneg_pipe`

## Requirements
- R1: While reset is held, halted is 0, no write enable is raised, and every bank port shows row 0, because fetch starts at address 0.
- R2: An instruction at address p takes A, B and C from the low AW bits of words p, p+1 and p+2. It stores mem[B] minus mem[A], modulo 2^DW, into mem[B]. It continues at C when bit DW-1 of that difference is 1 and at p+3 otherwise. The final memory equals the result of running the instructions one at a time.
- R3: Address x lives in bank x mod 3 at row x div 3. At most one bank write enable is high in any cycle.
- R4: When a write and an operand read need the same bank in one cycle, the write goes ahead and the read waits at least one cycle.
- R5: Operands A and B at different addresses in the same bank are read over two cycles, A first. When A equals B, a single read supplies both operands.
- R6: An operand read of an address that an older instruction still has to write waits until that write has been done.
- R7: A fetch that covers a word an older instruction still has to write waits, so that self-modifying code sees the new value.
- R8: A taken branch discards all younger instructions before any of them writes, and the next fetch comes from C.
- R9: A taken branch whose C equals its own address raises halted. halted then stays high, and no bank write follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_addr | output | 3 x RW | Row address for each bank |
| bank_we | output | 3 | Write enable for each bank |
| bank_wdata | output | 3 x DW | Write data for each bank |
| bank_rdata | input | 3 x DW | Read data from each bank, valid in the same cycle as its address |
| halted | output | 1 | High once the core has stopped |

## Verification
The bench builds the core with 6-bit addresses and 16-bit words. The whole 64-word memory then fits in a small model, and every final word can be compared against a sequential reference run. In this size, random programs of ten instructions plus a halting instruction keep hitting the interesting cases: same-bank operand pairs, back-to-back write and read collisions, dependency chains from one instruction to the next, rewrites of later instructions' A fields, and forward branches of every length. The top rows of banks 1 and 2 lie beyond address 63, and the bench's bank model returns zero for them.

// File: rtl/subneg_pkg.sv
package subneg_pkg;

    localparam int NBANK = 3;

    typedef enum logic {
        ST_RUN,
        ST_HALT
    } run_state_t;

    typedef enum logic {
        RD_FIRST,
        RD_SECOND
    } rd_phase_t;

    function automatic logic [1:0] bank_of(input logic [31:0] addr);
        return 2'(addr % 32'd3);
    endfunction

    function automatic logic [31:0] row_of(input logic [31:0] addr);
        return addr / 32'd3;
    endfunction

endpackage

// File: rtl/subneg_hazard.sv
module subneg_hazard
    import subneg_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic          run,
    input  logic          flush,
    input  logic [AW-1:0] pc,
    input  logic          r_valid,
    input  rd_phase_t     r_phase,
    input  logic [AW-1:0] r_a,
    input  logic [AW-1:0] r_b,
    input  logic          c_valid,
    input  logic [AW-1:0] c_b,
    input  logic          w_valid,
    input  logic [AW-1:0] w_b,
    output logic          w_write,
    output logic          rd_a,
    output logic          rd_b,
    output logic          r_go,
    output logic          r_split,
    output logic          f_go
);

    logic [2:0]    wmask;
    logic [1:0]    ba;
    logic [1:0]    bb;
    logic          raw;
    logic [AW-1:0] f_delta;
    logic          f_hit;

    assign w_write = w_valid && !flush;
    assign wmask   = w_write ? (3'b001 << bank_of(32'(w_b))) : 3'b000;
    assign ba      = bank_of(32'(r_a));
    assign bb      = bank_of(32'(r_b));

    // operands pending a write from an older instruction
    assign raw = (c_valid && (c_b == r_a || c_b == r_b)) ||
                 (w_valid && (w_b == r_a || w_b == r_b));

    always_comb begin
        rd_a    = 1'b0;
        rd_b    = 1'b0;
        r_go    = 1'b0;
        r_split = 1'b0;
        if (r_valid && !raw) begin
            unique case (r_phase)
                RD_FIRST: begin
                    if (r_a == r_b) begin
                        if (!wmask[ba]) begin
                            rd_a = 1'b1;
                            r_go = 1'b1;
                        end
                    end else if (ba == bb) begin
                        if (!wmask[ba]) begin
                            rd_a    = 1'b1;
                            r_split = 1'b1;
                        end
                    end else if (!wmask[ba] && !wmask[bb]) begin
                        rd_a = 1'b1;
                        rd_b = 1'b1;
                        r_go = 1'b1;
                    end
                end
                RD_SECOND: begin
                    if (!wmask[bb]) begin
                        rd_b = 1'b1;
                        r_go = 1'b1;
                    end
                end
            endcase
        end
    end

    // fetch needs every bank, so it runs only with read and write stages idle
    assign f_delta = c_b - pc;
    assign f_hit   = c_valid && (f_delta < AW'(3));
    assign f_go    = run && !flush && !r_valid && !w_valid && !f_hit;

endmodule

// File: rtl/subneg_bankmux.sv
module subneg_bankmux
    import subneg_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int RW = 5
) (
    input  logic                  w_write,
    input  logic [AW-1:0]         w_b,
    input  logic [DW-1:0]         w_res,
    input  logic                  rd_a,
    input  logic                  rd_b,
    input  logic [AW-1:0]         r_a,
    input  logic [AW-1:0]         r_b,
    input  logic [AW-1:0]         pc,
    output logic [2:0][RW-1:0]    bank_addr,
    output logic [2:0]            bank_we,
    output logic [2:0][DW-1:0]    bank_wdata
);

    for (genvar k = 0; k < NBANK; k++) begin : g_bank
        logic [1:0]    off;
        logic [AW-1:0] fa;
        logic          we_k;
        logic [RW-1:0] addr_k;

        assign off  = 2'((32'(k) + 32'd3 - 32'(bank_of(32'(pc)))) % 32'd3);
        assign fa   = pc + AW'(off);
        assign we_k = w_write && (bank_of(32'(w_b)) == 2'(k));

        always_comb begin
            if (we_k)
                addr_k = RW'(row_of(32'(w_b)));
            else if (rd_a && bank_of(32'(r_a)) == 2'(k))
                addr_k = RW'(row_of(32'(r_a)));
            else if (rd_b && bank_of(32'(r_b)) == 2'(k))
                addr_k = RW'(row_of(32'(r_b)));
            else
                addr_k = RW'(row_of(32'(fa)));
        end

        assign bank_addr[k]  = addr_k;
        assign bank_we[k]    = we_k;
        assign bank_wdata[k] = w_res;
    end

endmodule

// File: rtl/subneg_pipe.sv
module subneg_pipe
    import subneg_pkg::*;
#(
    parameter int AW = 6,
    parameter int DW = 16,
    parameter int RW = $clog2(((1 << AW) + 2) / 3)
) (
    input  logic               clk,
    input  logic               rst_n,
    output logic [2:0][RW-1:0] bank_addr,
    output logic [2:0]         bank_we,
    output logic [2:0][DW-1:0] bank_wdata,
    input  logic [2:0][DW-1:0] bank_rdata,
    output logic               halted
);

    run_state_t state, state_d;
    logic [AW-1:0] pc_q;

    logic          r_valid;
    rd_phase_t     r_phase;
    logic [AW-1:0] r_pc, r_a, r_b, r_c;
    logic [DW-1:0] r_va;

    logic          c_valid;
    logic [AW-1:0] c_pc, c_b, c_c;
    logic [DW-1:0] c_va, c_vb;

    logic          w_valid;
    logic [AW-1:0] w_pc, w_b, w_c;
    logic [DW-1:0] w_res;

    logic          b_valid;
    logic [AW-1:0] b_pc, b_c;
    logic          b_neg;

    logic flush, halt_now;
    logic w_write, rd_a, rd_b, r_go, r_split, f_go;
    logic [1:0] r_bank_a, r_bank_b, f_bank;
    logic [DW-1:0] data_a, data_b;
    logic [2:0][AW-1:0] fw;

    assign flush    = b_valid && b_neg;
    assign halt_now = flush && (b_c == b_pc);

    assign r_bank_a = bank_of(32'(r_a));
    assign r_bank_b = bank_of(32'(r_b));
    assign data_a   = bank_rdata[r_bank_a];
    assign data_b   = bank_rdata[r_bank_b];
    assign f_bank   = bank_of(32'(pc_q));

    for (genvar k = 0; k < NBANK; k++) begin : g_fw
        logic [1:0] src;
        assign src   = 2'((32'(f_bank) + 32'(k)) % 32'd3);
        assign fw[k] = bank_rdata[src][AW-1:0];
    end

    subneg_hazard #(.AW(AW)) u_hazard (
        .run     (state == ST_RUN),
        .flush   (flush),
        .pc      (pc_q),
        .r_valid (r_valid),
        .r_phase (r_phase),
        .r_a     (r_a),
        .r_b     (r_b),
        .c_valid (c_valid),
        .c_b     (c_b),
        .w_valid (w_valid),
        .w_b     (w_b),
        .w_write (w_write),
        .rd_a    (rd_a),
        .rd_b    (rd_b),
        .r_go    (r_go),
        .r_split (r_split),
        .f_go    (f_go)
    );

    subneg_bankmux #(.AW(AW), .DW(DW), .RW(RW)) u_bankmux (
        .w_write    (w_write),
        .w_b        (w_b),
        .w_res      (w_res),
        .rd_a       (rd_a),
        .rd_b       (rd_b),
        .r_a        (r_a),
        .r_b        (r_b),
        .pc         (pc_q),
        .bank_addr  (bank_addr),
        .bank_we    (bank_we),
        .bank_wdata (bank_wdata)
    );

    // run state
    always_comb begin
        state_d = state;
        unique case (state)
            ST_RUN:  if (halt_now) state_d = ST_HALT;
            ST_HALT: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_d;
    end

    assign halted = (state == ST_HALT);

    // pipeline registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q    <= '0;
            r_valid <= 1'b0;
            r_phase <= RD_FIRST;
            r_pc    <= '0;
            r_a     <= '0;
            r_b     <= '0;
            r_c     <= '0;
            r_va    <= '0;
            c_valid <= 1'b0;
            c_pc    <= '0;
            c_b     <= '0;
            c_c     <= '0;
            c_va    <= '0;
            c_vb    <= '0;
            w_valid <= 1'b0;
            w_pc    <= '0;
            w_b     <= '0;
            w_c     <= '0;
            w_res   <= '0;
            b_valid <= 1'b0;
            b_pc    <= '0;
            b_c     <= '0;
            b_neg   <= 1'b0;
        end else begin
            b_valid <= w_valid && !flush;
            b_pc    <= w_pc;
            b_c     <= w_c;
            b_neg   <= w_res[DW-1];

            w_valid <= c_valid && !flush;
            w_pc    <= c_pc;
            w_b     <= c_b;
            w_c     <= c_c;
            w_res   <= c_vb - c_va;

            c_valid <= r_go && !flush;
            c_pc    <= r_pc;
            c_b     <= r_b;
            c_c     <= r_c;
            c_vb    <= data_b;
            c_va    <= (r_phase == RD_SECOND) ? r_va : data_a;

            if (flush) begin
                r_valid <= 1'b0;
                r_phase <= RD_FIRST;
            end else if (f_go) begin
                r_valid <= 1'b1;
                r_phase <= RD_FIRST;
                r_pc    <= pc_q;
                r_a     <= fw[0];
                r_b     <= fw[1];
                r_c     <= fw[2];
            end else if (r_go) begin
                r_valid <= 1'b0;
                r_phase <= RD_FIRST;
            end else if (r_split) begin
                r_phase <= RD_SECOND;
                r_va    <= data_a;
            end

            if (flush)     pc_q <= b_c;
            else if (f_go) pc_q <= pc_q + AW'(3);
        end
    end

    // R3: one write port active at most
    assert_we_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));

    // R4: a write into the bank of operand A keeps the read stage occupied
    assert_write_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_valid && r_phase == RD_FIRST && bank_we[r_bank_a]) |=> r_valid);

    // R5: a split read moves to the second phase with the instruction held
    assert_split_second_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (r_split && !flush) |=> (r_valid && r_phase == RD_SECOND && $stable(r_b)));

    // R6: operands leave the read stage only when no older write is pending on them
    assert_raw_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        r_go |-> !(c_valid && (c_b == r_a || c_b == r_b)));

    // R7: a fetch never covers the target of the write waiting in compute
    assert_fetch_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        f_go |-> !(c_valid && AW'(c_b - pc_q) < AW'(3)));

    // R8: a taken branch empties the younger stages and redirects fetch
    assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!r_valid && !c_valid && !w_valid && !b_valid && pc_q == $past(b_c)));

    // R9: halt is permanent and silent
    assert_halt_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);
    assert_halt_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (bank_we == 3'b000));

endmodule

// File: tb/subneg_pipe_tb.sv
module subneg_pipe_tb;

    localparam int AW      = 6;
    localparam int DW      = 16;
    localparam int RW      = 5;
    localparam int DEPTH   = 64;
    localparam int K       = 10;
    localparam int HALT_PC = 30;
    localparam int ONE_AT  = 33;
    localparam int ZERO_AT = 34;
    localparam int DATA_LO = 36;
    localparam int NDATA   = 28;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0][RW-1:0] bank_addr;
    logic [2:0]         bank_we;
    logic [2:0][DW-1:0] bank_wdata;
    logic [2:0][DW-1:0] bank_rdata;
    logic               halted;

    logic [DW-1:0] mem   [DEPTH];
    logic [DW-1:0] ref_m [DEPTH];

    int vectors = 0;
    int misses = 0;
    int onehot_bad = 0;
    int halt_writes = 0;
    int unsigned seed = 32'd2024;

    always #10 clk = ~clk;

    subneg_pipe #(.AW(AW), .DW(DW), .RW(RW)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_addr  (bank_addr),
        .bank_we    (bank_we),
        .bank_wdata (bank_wdata),
        .bank_rdata (bank_rdata),
        .halted     (halted)
    );

    // three-bank memory model: address = row*3 + bank
    always_comb begin
        for (int k = 0; k < 3; k++)
            bank_rdata[k] = (int'(bank_addr[k]) * 3 + k < DEPTH) ?
                            mem[int'(bank_addr[k]) * 3 + k] : '0;
    end

    always @(posedge clk) begin
        for (int k = 0; k < 3; k++)
            if (bank_we[k] && int'(bank_addr[k]) * 3 + k < DEPTH)
                mem[int'(bank_addr[k]) * 3 + k] <= bank_wdata[k];
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (!$onehot0(bank_we)) onehot_bad = onehot_bad + 1;
            if (halted && bank_we != 3'b000) halt_writes = halt_writes + 1;
        end
    end

    function automatic int unsigned rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return (seed >> 16) & 32'h7fff;
    endfunction

    task automatic check(input string req, input string what,
                         input int unsigned act, input int unsigned exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic put(input int addr, input logic [DW-1:0] v);
        mem[addr]   <= v;
        ref_m[addr] = v;
    endtask

    task automatic build(input int mode);
        int a, b, c, pc, prev_b, r;
        for (int i = 0; i < DEPTH; i++) put(i, '0);
        for (int d = DATA_LO; d < DEPTH; d++) put(d, DW'(int'(rnd() % 16) - 8));
        put(ONE_AT, DW'(1));
        put(ZERO_AT, '0);
        prev_b = DATA_LO;
        for (int i = 0; i < K; i++) begin
            pc = 3 * i;
            a  = DATA_LO + int'(rnd() % NDATA);
            b  = DATA_LO + int'(rnd() % NDATA);
            c  = pc + 3;
            case (mode)
                1: if (i > 0) begin
                       if (rnd() % 2 == 0) a = prev_b;
                       else                b = prev_b;
                   end
                2: begin
                       if (rnd() % 4 == 0)  b = a;
                       else if (a + 3 < DEPTH) b = a + 3;
                       else                 b = a - 6;
                   end
                3: if (i < K - 1 && rnd() % 3 == 0)
                       b = 3 * (i + 1 + int'(rnd() % (K - 1 - i)));
                4: begin
                       r = int'(rnd() % 3);
                       c = (r == 0) ? pc + 3 : (r == 1) ? pc + 6 : HALT_PC;
                       if (c > HALT_PC) c = HALT_PC;
                   end
                default: ;
            endcase
            put(pc, DW'(a));
            put(pc + 1, DW'(b));
            put(pc + 2, DW'(c));
            prev_b = b;
        end
        put(HALT_PC, DW'(ONE_AT));
        put(HALT_PC + 1, DW'(ZERO_AT));
        put(HALT_PC + 2, DW'(HALT_PC));
    endtask

    // sequential reference: one instruction at a time
    task automatic ref_run();
        int pc, a, b, c;
        logic [DW-1:0] res;
        pc = 0;
        for (int step = 0; step < 500; step++) begin
            a   = int'(ref_m[pc][AW-1:0]);
            b   = int'(ref_m[pc + 1][AW-1:0]);
            c   = int'(ref_m[pc + 2][AW-1:0]);
            res = ref_m[b] - ref_m[a];
            ref_m[b] = res;
            if (res[DW-1]) begin
                if (c == pc) break;
                pc = c;
            end else begin
                pc = pc + 3;
            end
        end
    endtask

    initial begin : main
        string tag;
        for (int mode = 0; mode < 5; mode++) begin
            case (mode)
                0: tag = "R2";
                1: tag = "R4,R6";
                2: tag = "R5";
                3: tag = "R7";
                default: tag = "R8";
            endcase
            for (int s = 0; s < 8; s++) begin
                int n;
                rst_n = 1'b0;
                build(mode);
                repeat (2) @(negedge clk);
                onehot_bad  = 0;
                halt_writes = 0;
                // R1: outputs while reset is held
                check("R1", "reset halted/we/addr", int'({halted, bank_we, bank_addr}), 0);
                rst_n = 1'b1;
                n = 0;
                while (!halted && n < 3000) begin
                    @(negedge clk);
                    n++;
                end
                repeat (8) @(negedge clk);
                check("R9", "halted", int'(halted), 1);
                check("R9", "writes after halt", halt_writes, 0);
                check("R3", "cycles with two write enables", onehot_bad, 0);
                ref_run();
                for (int i = 0; i < DEPTH; i++)
                    check(tag, $sformatf("mode %0d seed %0d mem[%0d]", mode, s, i),
                          int'(mem[i]), int'(ref_m[i]));
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        vectors++;
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule